// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time as a set of BCD fields: seconds, minutes, hours (24-hour), day of month, month, two-digit year and a weekday counter. It is advanced by a single-cycle strobe that arrives at 32768 Hz in the system clock domain. A prescaler turns every `TICKS_PER_SEC` strobes into one second step. The step ripples through the calendar, which handles month lengths and leap years. The year field covers 2000 to 2099, so a year value that is a multiple of four is a leap year, and that includes 00.

Software reaches the block through a small byte-wide register bus. A write takes effect on the next clock edge. A read returns data combinationally from the addressed register. A run control starts and stops counting. A busy indication warns software that a second step is imminent, so it can time its reads and writes to miss the update. Four sticky event flags record second, minute, hour and day boundaries. The second flag can drive a level interrupt.

Top module: `cal_clock_top`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01, year 0x00 and weekday 0x00. Control, status and interrupt-enable read 0x00, and `irq_o` is low.
- R2: Register addresses are: seconds 0x00, minutes 0x04, hours 0x08, day 0x0C, month 0x10, year 0x14, weekday 0x18, control 0x40, status 0x44, interrupt enable 0x48.
  - Control bit 0 is run, where 1 means counting.
  - Status bit 0 is busy and bit 1 mirrors run. Status bits 2, 3, 4 and 5 are the second, minute, hour and day flags.
  - Interrupt-enable bit 2 enables the timer interrupt.
  - Unused bits read 0.
- R3: While run is 1, the seconds field advances once for every `TICKS_PER_SEC` tick strobes. While run is 0, tick strobes change no field.
- R4: Busy (status bit 0) is 1 only while running. It rises on the tick that leaves one tick remaining before the step, and falls on the tick that performs the step.
- R5: Seconds and minutes wrap from 0x59 to 0x00 and carry into the next field. Hours wrap from 0x23 to 0x00 and carry into the day. BCD digits roll from 9 to the next tens digit.
- R6: The day wraps to 0x01 after the last day of the month. The last day is 0x31 for months 01, 03, 05, 07, 08, 10 and 12, and 0x30 for months 04, 06, 09 and 11. February ends at 0x29 when the year is a multiple of four, including 00, and at 0x28 otherwise.
- R7: The month wraps from 0x12 to 0x01 and carries into the year. The year wraps from 0x99 to 0x00. The weekday counts 0 to 6 and advances on every day carry.
- R8: Each event flag is set when its unit increments and stays set until software writes 1 to that bit at 0x44. Writing 0 to a flag bit leaves it unchanged.
- R9: `irq_o` is high exactly while interrupt-enable bit 2 and the second flag are both 1.
- R10: A write to a time field loads the written value at the next edge. Any step falling in that cycle is dropped. Writing seconds also restarts the sub-second count, so the next step comes a full `TICKS_PER_SEC` strobes later.
- R11: Reads from unmapped addresses return 0x00. Writes to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle strobe at the 32768 Hz rate |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wr | input | 1 | Write strobe, applied at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Timer interrupt, level |

## Verification
The bound checker watches behaviours that hold on every cycle:
- Fields stay frozen while stopped with no write pending.
- Seconds roll from 59 to 00 on a step.
- Busy never appears without run.
- A set flag persists until a matching clear.
- The interrupt stays low when it is disabled.

Calendar correctness is shown only by the bench's scenarios: month lengths, leap years including year 00, the year and weekday wraps, the exact tick on which busy rises and falls, and the sub-second restart after a seconds write.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int NUM_FIELDS = 7;
    localparam int NUM_EVENTS = 4;

    typedef enum logic [2:0] {
        F_SEC  = 3'd0,
        F_MIN  = 3'd1,
        F_HOUR = 3'd2,
        F_DAY  = 3'd3,
        F_MON  = 3'd4,
        F_YEAR = 3'd5,
        F_WDAY = 3'd6
    } field_e;

    localparam logic [7:0] CTRL_OFF = 8'h40;
    localparam logic [7:0] STAT_OFF = 8'h44;
    localparam logic [7:0] IEN_OFF  = 8'h48;

    typedef struct packed {
        logic [7:0] wday;
        logic [7:0] year;
        logic [7:0] mon;
        logic [7:0] day;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_time_t;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // two-digit BCD year is a multiple of four
    function automatic logic is_leap(input logic [7:0] y);
        if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    function automatic logic [7:0] month_last_day(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic logic [7:0] get_field(input cal_time_t t, input logic [2:0] idx);
        case (idx)
            3'd0:    return t.sec;
            3'd1:    return t.min;
            3'd2:    return t.hour;
            3'd3:    return t.day;
            3'd4:    return t.mon;
            3'd5:    return t.year;
            3'd6:    return t.wday;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    input  logic restart,
    output logic step,
    output logic busy
);
    localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    assign at_last = (cnt_q == LAST);
    assign busy    = run && at_last;
    assign step    = busy && tick;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cal_calendar.sv
module cal_calendar
    import cal_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  step,
    input  logic [NUM_FIELDS-1:0] fld_wr,
    input  logic [7:0]            wdata,
    output cal_time_t             tm,
    output logic [NUM_EVENTS-1:0] ev
);
    cal_time_t tm_q;
    cal_time_t tm_d;
    logic      go;
    logic      mon_carry;
    logic      year_carry;

    assign tm = tm_q;
    assign go = step && (fld_wr == '0);

    assign ev[0]      = go;
    assign ev[1]      = ev[0] && (tm_q.sec  == 8'h59);
    assign ev[2]      = ev[1] && (tm_q.min  == 8'h59);
    assign ev[3]      = ev[2] && (tm_q.hour == 8'h23);
    assign mon_carry  = ev[3] && (tm_q.day == month_last_day(tm_q.mon, tm_q.year));
    assign year_carry = mon_carry && (tm_q.mon == 8'h12);

    always_comb begin
        tm_d = tm_q;
        if (go) tm_d.sec = ev[1] ? 8'h00 : bcd_inc(tm_q.sec);
        if (ev[1]) tm_d.min = ev[2] ? 8'h00 : bcd_inc(tm_q.min);
        if (ev[2]) tm_d.hour = ev[3] ? 8'h00 : bcd_inc(tm_q.hour);
        if (ev[3]) begin
            tm_d.day  = mon_carry ? 8'h01 : bcd_inc(tm_q.day);
            tm_d.wday = (tm_q.wday >= 8'h06) ? 8'h00 : tm_q.wday + 8'h01;
        end
        if (mon_carry) tm_d.mon = year_carry ? 8'h01 : bcd_inc(tm_q.mon);
        if (year_carry) tm_d.year = (tm_q.year == 8'h99) ? 8'h00 : bcd_inc(tm_q.year);
        if (fld_wr[F_SEC])  tm_d.sec  = wdata;
        if (fld_wr[F_MIN])  tm_d.min  = wdata;
        if (fld_wr[F_HOUR]) tm_d.hour = wdata;
        if (fld_wr[F_DAY])  tm_d.day  = wdata;
        if (fld_wr[F_MON])  tm_d.mon  = wdata;
        if (fld_wr[F_YEAR]) tm_d.year = wdata;
        if (fld_wr[F_WDAY]) tm_d.wday = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tm_q <= '{wday: 8'h00, year: 8'h00, mon: 8'h01, day: 8'h01,
                      hour: 8'h00, min: 8'h00, sec: 8'h00};
        end else begin
            tm_q <= tm_d;
        end
    end
endmodule

// File: rtl/cal_clock_top.sv
module cal_clock_top
    import cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int ADDR_W        = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq_o
);
    localparam int IEN_BIT = 2;

    cal_time_t             time_q;
    logic [NUM_FIELDS-1:0] fld_wr;
    logic [NUM_EVENTS-1:0] ev_w;
    logic [NUM_EVENTS-1:0] flag_q;
    logic [NUM_EVENTS-1:0] clr_w;
    logic                  run_q;
    logic                  ien_q;
    logic                  busy_w;
    logic                  step_w;
    logic                  fld_hit;
    logic [2:0]            fld_idx;
    logic                  hit_ctrl;
    logic                  hit_stat;
    logic                  hit_ien;
    logic [7:0]            sec_now;

    assign sec_now  = time_q.sec;
    assign fld_idx  = bus_addr[4:2];
    assign fld_hit  = (bus_addr[ADDR_W-1:5] == '0) && (bus_addr[1:0] == 2'b00)
                      && (int'(fld_idx) < NUM_FIELDS);
    assign hit_ctrl = (bus_addr == ADDR_W'(CTRL_OFF));
    assign hit_stat = (bus_addr == ADDR_W'(STAT_OFF));
    assign hit_ien  = (bus_addr == ADDR_W'(IEN_OFF));

    assign fld_wr = (bus_wr && fld_hit) ? NUM_FIELDS'(1) << fld_idx : '0;
    assign clr_w  = (bus_wr && hit_stat) ? bus_wdata[2 +: NUM_EVENTS] : '0;

    cal_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .run     (run_q),
        .tick    (tick_i),
        .restart (fld_wr[F_SEC]),
        .step    (step_w),
        .busy    (busy_w)
    );

    cal_calendar u_cal (
        .clk    (clk),
        .rst    (rst),
        .step   (step_w),
        .fld_wr (fld_wr),
        .wdata  (bus_wdata),
        .tm     (time_q),
        .ev     (ev_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            ien_q <= 1'b0;
        end else if (bus_wr) begin
            if (hit_ctrl) run_q <= bus_wdata[0];
            if (hit_ien)  ien_q <= bus_wdata[IEN_BIT];
        end
    end

    for (genvar i = 0; i < NUM_EVENTS; i++) begin : g_flag
        logic flag_b;
        always_ff @(posedge clk) begin
            if (rst)          flag_b <= 1'b0;
            else if (ev_w[i]) flag_b <= 1'b1;
            else if (clr_w[i]) flag_b <= 1'b0;
        end
        assign flag_q[i] = flag_b;
    end

    assign irq_o = ien_q && flag_q[0];

    always_comb begin
        bus_rdata = 8'h00;
        if (fld_hit)       bus_rdata = get_field(time_q, fld_idx);
        else if (hit_ctrl) bus_rdata = {7'd0, run_q};
        else if (hit_stat) bus_rdata = {2'd0, flag_q, run_q, busy_w};
        else if (hit_ien)  bus_rdata = 8'(ien_q) << IEN_BIT;
    end
endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk (
    input logic        clk,
    input logic        rst,
    input logic        run,
    input logic        busy,
    input logic [6:0]  fld_wr,
    input logic [55:0] tm_bits,
    input logic [7:0]  sec,
    input logic [3:0]  ev,
    input logic [3:0]  flag,
    input logic [3:0]  clr,
    input logic        ien,
    input logic        irq
);
    p_hold_stopped_r3: assert property (@(posedge clk) disable iff (rst)
        (!run && fld_wr == 7'd0) |=> $stable(tm_bits));

    p_busy_needs_run_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> run);

    p_sec_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (ev[0] && sec == 8'h59) |=> (sec == 8'h00));

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (flag[0] && !clr[0]) |=> flag[0]);

    p_irq_gated_r9: assert property (@(posedge clk) disable iff (rst)
        !ien |-> !irq);
endmodule

bind cal_clock_top cal_clock_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .run     (run_q),
    .busy    (busy_w),
    .fld_wr  (fld_wr),
    .tm_bits (time_q),
    .sec     (sec_now),
    .ev      (ev_w),
    .flag    (flag_q),
    .clr     (clr_w),
    .ien     (ien_q),
    .irq     (irq_o)
);

// File: tb/tb_cal_clock_top.sv
module tb_cal_clock_top;
    localparam int TPS = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_o;

    int total = 0;
    int bad = 0;

    cal_clock_top #(.TICKS_PER_SEC(TPS), .ADDR_W(8)) dut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    // start sec,min,hour,day,mon,year | expected after one step
    localparam logic [95:0] VEC [14] = '{
        96'h00_00_00_01_01_00_01_00_00_01_01_00,
        96'h59_00_00_01_01_00_00_01_00_01_01_00,
        96'h59_59_23_15_03_24_00_00_00_16_03_24,
        96'h59_59_23_30_04_21_00_00_00_01_05_21,
        96'h59_59_23_28_02_23_00_00_00_01_03_23,
        96'h59_59_23_28_02_24_00_00_00_29_02_24,
        96'h59_59_23_29_02_24_00_00_00_01_03_24,
        96'h59_59_23_31_12_99_00_00_00_01_01_00,
        96'h59_59_23_28_02_00_00_00_00_29_02_00,
        96'h59_59_09_31_01_05_00_00_10_31_01_05,
        96'h59_59_23_31_01_10_00_00_00_01_02_10,
        96'h59_59_23_30_06_12_00_00_00_01_07_12,
        96'h59_59_23_30_11_13_00_00_00_01_12_13,
        96'h59_59_23_31_10_13_00_00_00_01_11_13
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R3 got=hung exp=finished");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h00, d); chk("R1 sec", d, 8'h00);
        rd(8'h04, d); chk("R1 min", d, 8'h00);
        rd(8'h08, d); chk("R1 hour", d, 8'h00);
        rd(8'h0C, d); chk("R1 day", d, 8'h01);
        rd(8'h10, d); chk("R1 mon", d, 8'h01);
        rd(8'h14, d); chk("R1 year", d, 8'h00);
        rd(8'h18, d); chk("R1 wday", d, 8'h00);
        rd(8'h40, d); chk("R1 ctrl", d, 8'h00);
        rd(8'h44, d); chk("R1 status", d, 8'h00);
        rd(8'h48, d); chk("R1 ien", d, 8'h00);
        chk("R1 irq", {7'd0, irq_o}, 8'h00);

        // vector table: R5 R6 R7 rollover
        for (int v = 0; v < 14; v++) begin
            for (int k = 5; k >= 0; k--) wr(8'(4 * k), VEC[v][95 - 8*k -: 8]);
            wr(8'h40, 8'h01);
            ticks(TPS);
            wr(8'h40, 8'h00);
            for (int k = 0; k < 6; k++) begin
                rd(8'(4 * k), d);
                chk($sformatf("R5 R6 R7 vec%0d field%0d", v, k), d, VEC[v][47 - 8*k -: 8]);
            end
            wr(8'h44, 8'h3C);
        end

        // R4 busy window, R2 status layout, R3 one step per TPS ticks
        wr(8'h00, 8'h00);
        wr(8'h40, 8'h01);
        rd(8'h44, d); chk("R4 idle running", d, 8'h02);
        ticks(TPS - 1);
        rd(8'h44, d); chk("R4 busy before step", d, 8'h03);
        rd(8'h00, d); chk("R3 sec before step", d, 8'h00);
        ticks(1);
        rd(8'h44, d); chk("R4 busy cleared by step", d, 8'h06);
        rd(8'h00, d); chk("R3 sec after step", d, 8'h01);
        wr(8'h44, 8'h3C);
        wr(8'h40, 8'h00);

        // R3 stopped: ticks change nothing
        ticks(3 * TPS);
        rd(8'h00, d); chk("R3 stopped sec", d, 8'h01);
        rd(8'h44, d); chk("R4 no busy when stopped", d, 8'h00);

        // R7 weekday, R8 flags, R9 irq
        wr(8'h18, 8'h06);
        wr(8'h14, 8'h99); wr(8'h10, 8'h12); wr(8'h0C, 8'h31);
        wr(8'h08, 8'h23); wr(8'h04, 8'h59); wr(8'h00, 8'h59);
        wr(8'h40, 8'h01);
        ticks(TPS);
        wr(8'h40, 8'h00);
        rd(8'h18, d); chk("R7 weekday wrap", d, 8'h00);
        rd(8'h44, d); chk("R8 all flags set", d, 8'h3C);
        chk("R9 irq off when disabled", {7'd0, irq_o}, 8'h00);
        wr(8'h48, 8'h04);
        rd(8'h48, d); chk("R2 ien readback", d, 8'h04);
        chk("R9 irq on", {7'd0, irq_o}, 8'h01);
        wr(8'h44, 8'h00);
        rd(8'h44, d); chk("R8 write zero keeps flags", d, 8'h3C);
        wr(8'h44, 8'h04);
        rd(8'h44, d); chk("R8 clear second flag", d, 8'h38);
        chk("R9 irq off after clear", {7'd0, irq_o}, 8'h00);
        wr(8'h44, 8'h38);
        rd(8'h44, d); chk("R8 clear rest", d, 8'h00);
        wr(8'h48, 8'h00);

        // R10 writes load at once and restart sub-second count
        wr(8'h08, 8'h17);
        rd(8'h08, d); chk("R10 hour write", d, 8'h17);
        wr(8'h00, 8'h30);
        wr(8'h40, 8'h01);
        ticks(2);
        wr(8'h00, 8'h40);
        ticks(TPS - 1);
        rd(8'h00, d); chk("R10 restart holds", d, 8'h40);
        ticks(1);
        rd(8'h00, d); chk("R10 full second after write", d, 8'h41);
        wr(8'h40, 8'h00);

        // R11 unmapped space
        rd(8'h3C, d); chk("R11 read 0x3C", d, 8'h00);
        rd(8'h1C, d); chk("R11 read 0x1C", d, 8'h00);
        wr(8'h60, 8'hFF);
        wr(8'h01, 8'h77);
        rd(8'h00, d); chk("R11 sec untouched", d, 8'h41);
        rd(8'h40, d); chk("R11 ctrl untouched", d, 8'h00);
        rd(8'h48, d); chk("R11 ien untouched", d, 8'h00);

        finish_run();
    end
endmodule